// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block handles the even-parity duties of an agent on a 32-bit multiplexed address/data bus with four active-low command/byte-enable lines. Whenever the agent drives the AD and C/BE lines in a clock, the block computes the parity bit over them. It places that bit, with its enable, on the bus in the following clock, so that the ones across AD, C/BE and PAR add up to an even number.

When another agent drives the bus, the block captures AD and C/BE on each rising edge. It compares their parity with the PAR value that arrives one clock later. A completed data phase in error pulls the active-low data-error output low in the clock after the PAR clock. A bad address phase, or a bad data phase of a Special Cycle transaction, uses a separate active-low system-error output instead.

The data-error pin behaves as a sustained tri-state. It is driven low for each erroneous phase, driven high for one clock after the last low clock, and then released. All pins are plain level signals sampled on the rising clock edge. Nothing carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pci_parity_unit`

## Requirements
- R1: When `drive_i` is sampled high at an edge, then after that edge `par_o` equals the XOR of all 36 bits of the `ad_i` and `cbe_n_i` values sampled at that edge, which makes the total count of ones even.
- R2: `par_oe_o` is high in the clock after an edge that sampled `drive_i` high, and low in the clock after an edge that sampled it low.
- R3: A data phase is an edge with `irdy_n_i` and `trdy_n_i` both low that is not an address phase. If it is not driven by this agent and the `par_i` sampled at the next edge is wrong, `perr_n_o` is low in the clock following that next edge, which is two edges after the data.
- R4: Back-to-back erroneous data phases keep `perr_n_o` low for one clock per phase, in consecutive clocks.
- R5: `perr_oe_o` is high in every clock in which `perr_n_o` is low, and in the one clock after the last low clock, when `perr_n_o` is high. At all other times it is low.
- R6: An address phase is an edge where `frame_n_i` is low and was high at the previous edge. If such a phase is not driven by this agent and has wrong parity, `serr_n_o` is low for one clock at the same latency as R3. `perr_n_o` stays high.
- R7: A transaction whose command on `cbe_n_i` at the address phase is 4'b0001 (Special Cycle) reports its data-phase parity errors on `serr_n_o` and never on `perr_n_o`.
- R8: While `rst_n` is low: `par_oe_o` and `perr_oe_o` are low, and `perr_n_o` and `serr_n_o` are high.
- R9: Phases sampled with `drive_i` high are never checked. Wrong parity on them leaves `perr_n_o` and `serr_n_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data lines as seen on the bus |
| cbe_n_i | input | 4 | Command/byte-enable lines, active low |
| par_i | input | 1 | Parity line as seen on the bus |
| frame_n_i | input | 1 | Transaction frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| drive_i | input | 1 | This agent drives AD and C/BE in this clock |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Output enable for `par_o` |
| perr_n_o | output | 1 | Data parity error, active low |
| perr_oe_o | output | 1 | Output enable for `perr_n_o` |
| serr_n_o | output | 1 | System error, active low |

## Verification
The bench runs a long series of transactions that mix reads, writes, Special Cycles and phases driven by this agent. Wait states are inserted, and corrupted parity is injected either on every phase or in a sparse pattern. The expected values of all five outputs are derived each clock from the history of the stimulus.

- Latency: a design that reports one clock early or late fails the two-edge check.
- Wait states: a design that checks a wait-state clock raises a false error.
- Special Cycles: a design that forgets the latched Special Cycle command sends the error to the wrong pin.
- Release: a design that drops the enable together with the error, or never drops it, breaks the one-clock high tail.

Walking-one and all-command sweeps on the driven side cover each bit's share of the generated parity.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
  localparam int AD_W  = 32;
  localparam int CBE_W = 4;
  // Command code that marks a broadcast (Special Cycle) transaction
  localparam logic [CBE_W-1:0] CMD_SPECIAL = 4'b0001;
endpackage

// File: rtl/pci_par_xor.sv
module pci_par_xor #(
  parameter int W    = 32,
  parameter int CW   = 4,
  parameter int LANE = 8
) (
  input  logic [W-1:0]  ad_i,
  input  logic [CW-1:0] cbe_i,
  output logic          sum_o
);
  localparam int NL = (W + LANE - 1) / LANE;
  logic [NL-1:0] lane_x;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    localparam int LO = g * LANE;
    localparam int HI = (LO + LANE > W) ? W - 1 : LO + LANE - 1;
    assign lane_x[g] = ^ad_i[HI:LO];
  end

  assign sum_o = (^lane_x) ^ (^cbe_i);
endmodule

// File: rtl/pci_par_phase.sv
module pci_par_phase
  import pci_par_pkg::*;
#(
  parameter int CW = CBE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n_i,
  input  logic          irdy_n_i,
  input  logic          trdy_n_i,
  input  logic [CW-1:0] cbe_n_i,
  output logic          addr_ph_o,
  output logic          data_ph_o,
  output logic          special_o
);
  logic frame_q, special_q;

  assign addr_ph_o = !frame_n_i && frame_q;
  assign data_ph_o = !irdy_n_i && !trdy_n_i && !addr_ph_o;
  assign special_o = special_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q   <= 1'b1;
      special_q <= 1'b0;
    end else begin
      frame_q <= frame_n_i;
      if (addr_ph_o) special_q <= (cbe_n_i == CMD_SPECIAL);
    end
  end
endmodule

// File: rtl/pci_par_drive.sv
module pci_par_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_i,
  input  logic sum_i,
  output logic par_o,
  output logic par_oe_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_o    <= 1'b0;
      par_oe_o <= 1'b0;
    end else begin
      par_oe_o <= drive_i;
      if (drive_i) par_o <= sum_i;
    end
  end

  AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    drive_i |=> par_oe_o);  // R2
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_i |=> !par_oe_o);  // R2
endmodule

// File: rtl/pci_par_check.sv
module pci_par_check (
  input  logic clk,
  input  logic rst_n,
  input  logic sum_i,
  input  logic par_i,
  input  logic data_ph_i,
  input  logic addr_ph_i,
  input  logic special_i,
  input  logic ours_i,
  output logic perr_n_o,
  output logic perr_oe_o,
  output logic serr_n_o
);
  logic chk_data_q, chk_addr_q, chk_spec_q, sum_q;
  logic perr_q, perr_tail_q, serr_q;
  logic mism;

  assign mism = sum_q ^ par_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_data_q  <= 1'b0;
      chk_addr_q  <= 1'b0;
      chk_spec_q  <= 1'b0;
      sum_q       <= 1'b0;
      perr_q      <= 1'b0;
      perr_tail_q <= 1'b0;
      serr_q      <= 1'b0;
    end else begin
      chk_data_q  <= data_ph_i && !ours_i;
      chk_addr_q  <= addr_ph_i && !ours_i;
      chk_spec_q  <= special_i;
      sum_q       <= sum_i;
      perr_q      <= chk_data_q && !chk_spec_q && mism;
      serr_q      <= mism && (chk_addr_q || (chk_data_q && chk_spec_q));
      perr_tail_q <= perr_q;
    end
  end

  assign perr_n_o  = !perr_q;
  assign perr_oe_o = perr_q || perr_tail_q;
  assign serr_n_o  = !serr_q;

  AST_PERR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> perr_oe_o);  // R5
  AST_PERR_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr_n_o) |-> perr_oe_o);  // R5
  AST_PERR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_n_o && $past(perr_n_o)) |-> !perr_oe_o);  // R5
  AST_SPECIAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_data_q && chk_spec_q) |=> perr_n_o);  // R7
  AST_OURS_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
    ours_i |=> ##1 (perr_n_o && serr_n_o));  // R9
  AST_ONE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(!perr_n_o && !serr_n_o));  // R6
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_par_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_n_i,
  input  logic             par_i,
  input  logic             frame_n_i,
  input  logic             irdy_n_i,
  input  logic             trdy_n_i,
  input  logic             drive_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_n_o,
  output logic             perr_oe_o,
  output logic             serr_n_o
);
  logic sum, addr_ph, data_ph, special;

  pci_par_xor #(.W(AD_W), .CW(CBE_W), .LANE(8)) u_xor (
    .ad_i(ad_i), .cbe_i(cbe_n_i), .sum_o(sum));

  pci_par_phase #(.CW(CBE_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i),
    .trdy_n_i(trdy_n_i), .cbe_n_i(cbe_n_i), .addr_ph_o(addr_ph),
    .data_ph_o(data_ph), .special_o(special));

  pci_par_drive u_drive (
    .clk(clk), .rst_n(rst_n), .drive_i(drive_i), .sum_i(sum),
    .par_o(par_o), .par_oe_o(par_oe_o));

  pci_par_check u_check (
    .clk(clk), .rst_n(rst_n), .sum_i(sum), .par_i(par_i),
    .data_ph_i(data_ph), .addr_ph_i(addr_ph), .special_i(special),
    .ours_i(drive_i), .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o),
    .serr_n_o(serr_n_o));

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe_o |-> (($countones({$past(ad_i), $past(cbe_n_i)}) + int'(par_o)) % 2 == 0));  // R1
endmodule

// File: tb/pci_parity_unit_tb_top.sv
module pci_parity_unit_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic        par_in, frame_n, irdy_n, trdy_n, drive;
  logic        par_o, par_oe_o, perr_n_o, perr_oe_o, serr_n_o;

  pci_parity_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe_n), .par_i(par_in),
    .frame_n_i(frame_n), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n), .drive_i(drive),
    .par_o(par_o), .par_oe_o(par_oe_o), .perr_n_o(perr_n_o),
    .perr_oe_o(perr_oe_o), .serr_n_o(serr_n_o));

  typedef struct packed {
    logic        drive, bad, addr, cdata, spec;
    logic [31:0] ad;
    logic [3:0]  cbe;
  } ph_t;

  int   checks = 0, failures = 0;
  bit   done = 0;
  ph_t  h1, h2;
  logic prev_frame, exp_perr_prev;

  function automatic logic even_bit(logic [31:0] a, logic [3:0] c);
    return logic'($countones({a, c}) % 2);
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Check outputs produced by earlier edges, then apply the next clock's inputs.
  task automatic tick(logic fr, logic ir, logic tr, logic [31:0] a, logic [3:0] c,
                      logic drv, logic bad, logic spec);
    logic exp_perr, exp_serr;
    ph_t  cur;
    exp_perr = h2.cdata && !h2.spec && h2.bad;
    exp_serr = h2.bad && ((h2.addr && !h2.drive) || (h2.cdata && h2.spec));
    check("R2", par_oe_o, h1.drive, "par_oe");
    if (h1.drive) check("R1", par_o, even_bit(h1.ad, h1.cbe), "par");
    check(exp_perr && exp_perr_prev ? "R4" : (h2.spec ? "R7" : (h2.drive ? "R9" : "R3")),
          perr_n_o, !exp_perr, "perr_n");
    check(h2.spec ? "R7" : (h2.drive ? "R9" : "R6"), serr_n_o, !exp_serr, "serr_n");
    check("R5", perr_oe_o, exp_perr || exp_perr_prev, "perr_oe");
    exp_perr_prev = exp_perr;

    cur.drive = drv; cur.bad = bad; cur.spec = spec; cur.ad = a; cur.cbe = c;
    cur.addr  = !fr && prev_frame;
    cur.cdata = !ir && !tr && !cur.addr && !drv;
    par_in  = even_bit(h1.ad, h1.cbe) ^ h1.bad;
    frame_n = fr; irdy_n = ir; trdy_n = tr; ad = a; cbe_n = c; drive = drv;
    prev_frame = fr;
    h2 = h1; h1 = cur;
    @(negedge clk);
  endtask

  task automatic idle();
    tick(1'b1, 1'b1, 1'b1, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic txn(int t);
    logic ours, spec, allbad;
    int   nph;
    ours   = logic'(t % 2);
    spec   = (t % 5 == 3);
    allbad = (t % 7 == 1);
    nph    = 1 + (t % 4);
    tick(1'b0, 1'b1, 1'b1, t * 32'h0104_0300, spec ? 4'b0001 : (ours ? 4'b0111 : 4'b0110),
         ours, allbad || (t % 3 == 0), 1'b0);
    for (int p = 0; p < nph; p++) begin
      if ((t + p) % 3 == 0)
        tick(1'b0, 1'b0, 1'b1, 32'hDEAD_0000 + p, 4'h0, ours, 1'b1, spec);
      tick((p == nph - 1), 1'b0, 1'b0, (t * 32'h9E37_79B1) ^ (p * 32'h85EB_CA6B),
           4'(t + p), ours, allbad || ((t * 3 + p) % 4 == 0), spec);
    end
    idle();
  endtask

  initial begin
    rst_n = 1'b0; ad = '0; cbe_n = 4'hF; par_in = 1'b0;
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; drive = 1'b0;
    h1 = '0; h2 = '0; prev_frame = 1'b1; exp_perr_prev = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", par_oe_o, 0, "par_oe in reset");
    check("R8", perr_oe_o, 0, "perr_oe in reset");
    check("R8", perr_n_o, 1, "perr_n in reset");
    check("R8", serr_n_o, 1, "serr_n in reset");
    rst_n = 1'b1;
    @(negedge clk);
    // Driven-side sweeps: walking one over AD, then every C/BE value.
    for (int k = 0; k < 32; k++) tick(1'b1, 1'b1, 1'b1, 32'h1 << k, 4'hF, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 16; k++) tick(1'b1, 1'b1, 1'b1, 32'h0, 4'(k), 1'b1, 1'b0, 1'b0);
    idle(); idle();
    for (int t = 0; t < 140; t++) txn(t);
    idle(); idle(); idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule